// File: doc/BRIEF.md
# I2C Host Status and Interrupt Flags

This block is the status register of an I2C host controller. The host bit engine sends it single-cycle event strobes. These report a finished byte read, a finished address or byte write, the start of a clock stretch, a lost arbitration, a protocol violation on the bus, a sampled acknowledge bit, and the start and stop conditions seen on the bus. The block turns those strobes into sticky flags. It also tracks the state of the bus in a small state machine, and it drives the status byte together with two interrupt requests.

Software clears the flags through side effects of ordinary register accesses. A status write clears each flag whose data bit is 1. Writing the address register, reading or writing the data register, or writing the control register also clears the completion, clock-hold and arbitration flags. The bus-error flag ignores the data and control accesses. It clears only on an explicit write of 1 or on an address-register write.

The bus state machine has four states with fixed codes: UNKNOWN = 0, IDLE = 1, OWNER = 2 and BUSY = 3. Its transitions are listed here from highest to lowest priority:
- FORCE_IDLE: a status write whose low two data bits are 01 sends any state to IDLE.
- ERR_RESYNC: a bus-error strobe sends any state to UNKNOWN.
- STOP_SEEN: a stop strobe sends any state to IDLE.
- ARB_DROP: an arbitration-lost strobe sends OWNER to BUSY.
- OWN_START: a start issued by this host sends IDLE, OWNER or BUSY to OWNER.
- FOREIGN_START: a start issued by another host sends any state to BUSY.

Top module: `i2c_host_status`

## Requirements
- R1: After reset, `status_o` is 0x00, the bus state is UNKNOWN, and both interrupt requests are low.
- R2: The status byte holds, from bit 7 down to bit 0: read flag, write flag, clock hold, received ACK, arbitration lost, bus error, and bus state[1:0]. A `rd_done_i` strobe sets bit 7 on the next clock edge.
- R3: A `wr_done_i` strobe sets bit 6. This also happens when `arb_lost_i` or `bus_err_i` strobes in the same cycle.
- R4: The read flag, write flag, clock hold and arbitration lost each clear on any of the following: a status write with that data bit at 1, a write to the address register (address 3), a read or write of the data register (address 4), or a write to the control register (address 1). A read of the status register (address 2) clears nothing.
- R5: The bus-error flag (bit 2) clears only on a status write with data bit 2 at 1, or on an address-register write. Data and control accesses leave it set.
- R6: Bit 4 loads `ack_nack_i` on an `ack_smp_i` strobe (0 means ACK, 1 means NACK). Any other status write or access leaves bit 4 unchanged.
- R7: When a set strobe and a clear trigger for the same flag occur in one cycle, the flag ends up set.
- R8: Writing 0 to a flag bit of the status register leaves that flag unchanged.
- R9: `rd_irq_o` equals bit 7 ANDed with `rd_ien_i`. `wr_irq_o` equals bit 6 ANDed with `wr_ien_i`.
- R10: A status write with data bits [1:0] = 01 forces the bus state to IDLE. This has priority over every other transition. Any other value written to those bits is ignored.
- R11: The bus state follows the transitions ERR_RESYNC, STOP_SEEN, ARB_DROP, OWN_START and FOREIGN_START, in that priority order. An arbitration loss outside OWNER does not change the state.
- R12: A `hold_i` strobe sets bit 5. Bit 5 stays set until one of the R4 clear triggers occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| rd_done_i | input | 1 | Host byte read finished |
| wr_done_i | input | 1 | Address or byte write finished |
| hold_i | input | 1 | Host started holding the clock line low |
| arb_lost_i | input | 1 | Arbitration lost |
| bus_err_i | input | 1 | Protocol violation detected |
| ack_smp_i | input | 1 | Acknowledge bit sampled |
| ack_nack_i | input | 1 | Sampled acknowledge value (1 = NACK) |
| start_mine_i | input | 1 | This host issued a start or repeated start |
| start_other_i | input | 1 | Another host issued a start |
| stop_i | input | 1 | Stop condition seen |
| rd_ien_i | input | 1 | Read interrupt enable |
| wr_ien_i | input | 1 | Write interrupt enable |
| status_o | output | 8 | Status byte |
| rd_irq_o | output | 1 | Read interrupt request |
| wr_irq_o | output | 1 | Write interrupt request |

## Verification
The bench sends a write-complete strobe in the same cycle as an address write. A design that gives clear priority would lose that completion. The bench also sets the bus-error flag and then performs data and control accesses. A design that shares one clear path between all flags would drop the error at that point. Status writes of 0xFF and 0x08 check two things: that the acknowledge bit and the bus-state field survive while all the flags clear, and that a 0 written to the error bit does not clear it. The state-machine corner cases are a force-to-IDLE in the same cycle as a bus error, a repeated start while OWNER, and an arbitration loss while IDLE. Each of these would show a wrong state code in the low two bits.

// File: rtl/i2c_hstat_pkg.sv
package i2c_hstat_pkg;

    localparam int STAT_W = 8;

    // bit positions inside the status byte; software decodes these
    localparam int POS_RDF  = 7;
    localparam int POS_WRF  = 6;
    localparam int POS_HOLD = 5;
    localparam int POS_NACK = 4;
    localparam int POS_ARB  = 3;
    localparam int POS_BERR = 2;

    // sticky flag indices inside the flag vector
    localparam int F_RDF  = 0;
    localparam int F_WRF  = 1;
    localparam int F_HOLD = 2;
    localparam int F_ARB  = 3;
    localparam int F_BERR = 4;
    localparam int NFLAG  = 5;

    typedef enum logic [1:0] {
        BS_UNKNOWN = 2'd0,
        BS_IDLE    = 2'd1,
        BS_OWNER   = 2'd2,
        BS_BUSY    = 2'd3
    } bus_state_e;

    typedef struct packed {
        logic              common;      // address write, data access, control write
        logic              addr_wr;     // address register written
        logic              force_idle;  // bus state field written with IDLE
        logic [STAT_W-1:0] w1c;         // write-one-to-clear mask
    } clr_t;

endpackage

// File: rtl/i2c_hstat_decode.sv
module i2c_hstat_decode
    import i2c_hstat_pkg::*;
#(
    parameter int                ADDR_W = 3,
    parameter logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1),
    parameter logic [ADDR_W-1:0] A_STAT = ADDR_W'(2),
    parameter logic [ADDR_W-1:0] A_ADDR = ADDR_W'(3),
    parameter logic [ADDR_W-1:0] A_DATA = ADDR_W'(4)
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [STAT_W-1:0] bus_wdata,
    output clr_t              clr_o
);

    logic wr_stat, wr_addr, wr_ctrl, acc_data;

    always_comb begin
        wr_stat  = bus_wr && (bus_addr == A_STAT);
        wr_addr  = bus_wr && (bus_addr == A_ADDR);
        wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
        acc_data = (bus_wr || bus_rd) && (bus_addr == A_DATA);

        clr_o.common     = wr_addr || wr_ctrl || acc_data;
        clr_o.addr_wr    = wr_addr;
        clr_o.w1c        = wr_stat ? bus_wdata : '0;
        clr_o.force_idle = wr_stat && (bus_wdata[1:0] == BS_IDLE);
    end

endmodule

// File: rtl/i2c_hstat_flag.sv
module i2c_hstat_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= RST_VAL;
        else if (set_i)
            q_o <= 1'b1;      // a set beats a clear in the same cycle
        else if (clr_i)
            q_o <= 1'b0;
    end

endmodule

// File: rtl/i2c_hstat_busfsm.sv
module i2c_hstat_busfsm
    import i2c_hstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       force_idle_i,
    input  logic       bus_err_i,
    input  logic       stop_i,
    input  logic       arb_lost_i,
    input  logic       start_mine_i,
    input  logic       start_other_i,
    output logic [1:0] state_o
);

    bus_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= BS_UNKNOWN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (force_idle_i) begin
            state_d = BS_IDLE;                 // FORCE_IDLE
        end else if (bus_err_i) begin
            state_d = BS_UNKNOWN;              // ERR_RESYNC
        end else if (stop_i) begin
            state_d = BS_IDLE;                 // STOP_SEEN
        end else begin
            unique case (state_q)
                BS_UNKNOWN: begin
                    if (start_other_i) state_d = BS_BUSY;        // FOREIGN_START
                end
                BS_IDLE: begin
                    if (start_mine_i)       state_d = BS_OWNER;  // OWN_START
                    else if (start_other_i) state_d = BS_BUSY;   // FOREIGN_START
                end
                BS_OWNER: begin
                    if (arb_lost_i)         state_d = BS_BUSY;   // ARB_DROP
                    else if (start_mine_i)  state_d = BS_OWNER;  // OWN_START (repeated)
                    else if (start_other_i) state_d = BS_BUSY;   // FOREIGN_START
                end
                BS_BUSY: begin
                    if (start_mine_i)       state_d = BS_OWNER;  // OWN_START
                    else if (start_other_i) state_d = BS_BUSY;   // FOREIGN_START
                end
                default: state_d = BS_UNKNOWN;
            endcase
        end
    end

    always_comb begin
        state_o = state_q;
    end

endmodule

// File: rtl/i2c_host_status.sv
module i2c_host_status
    import i2c_hstat_pkg::*;
#(
    parameter int                ADDR_W = 3,
    parameter logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1),
    parameter logic [ADDR_W-1:0] A_STAT = ADDR_W'(2),
    parameter logic [ADDR_W-1:0] A_ADDR = ADDR_W'(3),
    parameter logic [ADDR_W-1:0] A_DATA = ADDR_W'(4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              rd_done_i,
    input  logic              wr_done_i,
    input  logic              hold_i,
    input  logic              arb_lost_i,
    input  logic              bus_err_i,
    input  logic              ack_smp_i,
    input  logic              ack_nack_i,
    input  logic              start_mine_i,
    input  logic              start_other_i,
    input  logic              stop_i,
    input  logic              rd_ien_i,
    input  logic              wr_ien_i,
    output logic [7:0]        status_o,
    output logic              rd_irq_o,
    output logic              wr_irq_o
);

    localparam int FPOS [NFLAG] = '{POS_RDF, POS_WRF, POS_HOLD, POS_ARB, POS_BERR};

    clr_t             clr;
    logic [NFLAG-1:0] set_v, clr_v, flag_q;
    logic [1:0]       bstate;
    logic             nack_q;

    i2c_hstat_decode #(
        .ADDR_W (ADDR_W),
        .A_CTRL (A_CTRL),
        .A_STAT (A_STAT),
        .A_ADDR (A_ADDR),
        .A_DATA (A_DATA)
    ) dec_i (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .clr_o     (clr)
    );

    always_comb begin
        set_v[F_RDF]  = rd_done_i;
        set_v[F_WRF]  = wr_done_i;
        set_v[F_HOLD] = hold_i;
        set_v[F_ARB]  = arb_lost_i;
        set_v[F_BERR] = bus_err_i;
    end

    generate
        for (genvar g = 0; g < NFLAG; g++) begin : g_flag
            if (g == F_BERR) begin : g_narrow
                assign clr_v[g] = clr.addr_wr || clr.w1c[FPOS[g]];
            end else begin : g_wide
                assign clr_v[g] = clr.common || clr.w1c[FPOS[g]];
            end
            i2c_hstat_flag #(.RST_VAL(1'b0)) flag_i (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_v[g]),
                .clr_i (clr_v[g]),
                .q_o   (flag_q[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            nack_q <= 1'b0;
        else if (ack_smp_i)
            nack_q <= ack_nack_i;
    end

    i2c_hstat_busfsm fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .force_idle_i  (clr.force_idle),
        .bus_err_i     (bus_err_i),
        .stop_i        (stop_i),
        .arb_lost_i    (arb_lost_i),
        .start_mine_i  (start_mine_i),
        .start_other_i (start_other_i),
        .state_o       (bstate)
    );

    always_comb begin
        status_o           = '0;
        status_o[POS_RDF]  = flag_q[F_RDF];
        status_o[POS_WRF]  = flag_q[F_WRF];
        status_o[POS_HOLD] = flag_q[F_HOLD];
        status_o[POS_NACK] = nack_q;
        status_o[POS_ARB]  = flag_q[F_ARB];
        status_o[POS_BERR] = flag_q[F_BERR];
        status_o[1:0]      = bstate;
        rd_irq_o           = flag_q[F_RDF] && rd_ien_i;
        wr_irq_o           = flag_q[F_WRF] && wr_ien_i;
    end

endmodule

// File: rtl/i2c_host_status_chk.sv
module i2c_host_status_chk #(
    parameter int                ADDR_W = 3,
    parameter logic [ADDR_W-1:0] A_STAT = ADDR_W'(2),
    parameter logic [ADDR_W-1:0] A_ADDR = ADDR_W'(3)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              rd_done_i,
    input logic              bus_err_i,
    input logic              ack_smp_i,
    input logic              rd_ien_i,
    input logic [7:0]        status_o,
    input logic              rd_irq_o
);

    assert_rdirq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_irq_o |-> (status_o[7] && rd_ien_i));

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_i |=> status_o[7]);

    assert_berr_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_i |=> status_o[2]);

    assert_berr_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[2] && !(bus_wr && (bus_addr == A_ADDR ||
                                     (bus_addr == A_STAT && bus_wdata[2]))))
        |=> status_o[2]);

    assert_nack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_smp_i |=> $stable(status_o[4]));

    assert_force_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STAT && bus_wdata[1:0] == 2'b01)
        |=> (status_o[1:0] == 2'b01));

    assert_addr_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ADDR && !rd_done_i) |=> !status_o[7]);

endmodule

bind i2c_host_status i2c_host_status_chk #(
    .ADDR_W (ADDR_W),
    .A_STAT (A_STAT),
    .A_ADDR (A_ADDR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rd_done_i (rd_done_i),
    .bus_err_i (bus_err_i),
    .ack_smp_i (ack_smp_i),
    .rd_ien_i  (rd_ien_i),
    .status_o  (status_o),
    .rd_irq_o  (rd_irq_o)
);

// File: tb/i2c_host_status_tb_top.sv
`timescale 1ns/1ps
module i2c_host_status_tb_top;

    localparam logic [2:0] CT = 3'd1, ST = 3'd2, AD = 3'd3, DA = 3'd4;

    // ev: rd_done, wr_done, hold, arb_lost, bus_err, ack_smp, ack_nack
    // bs: start_mine, start_other, stop ; op: wr, rd ; ien/irq: rd, wr
    typedef struct packed {
        logic [6:0] ev;
        logic [2:0] bs;
        logic [1:0] op;
        logic [2:0] addr;
        logic [7:0] wd;
        logic [1:0] ien;
        logic [7:0] exp_st;
        logic [1:0] exp_irq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        '{7'b0000000, 3'b000, 2'b00, 3'd0, 8'h00, 2'b11, 8'h00, 2'b00, 4'd1 },  // R1 idle
        '{7'b0000000, 3'b000, 2'b10, ST,   8'h01, 2'b11, 8'h01, 2'b00, 4'd10},  // R10 force idle
        '{7'b0000000, 3'b100, 2'b00, 3'd0, 8'h00, 2'b11, 8'h02, 2'b00, 4'd11},  // R11 own start
        '{7'b0100000, 3'b000, 2'b00, 3'd0, 8'h00, 2'b11, 8'h42, 2'b01, 4'd3 },  // R3 write done
        '{7'b0000011, 3'b000, 2'b00, 3'd0, 8'h00, 2'b11, 8'h52, 2'b01, 4'd6 },  // R6 NACK
        '{7'b0000000, 3'b000, 2'b10, ST,   8'h40, 2'b11, 8'h12, 2'b00, 4'd4 },  // R4 w1c write flag
        '{7'b1010000, 3'b000, 2'b00, 3'd0, 8'h00, 2'b11, 8'hB2, 2'b10, 4'd2 },  // R2 R12 read done+hold
        '{7'b0000000, 3'b000, 2'b01, DA,   8'h00, 2'b11, 8'h12, 2'b00, 4'd4 },  // R4 data read
        '{7'b0000010, 3'b000, 2'b00, 3'd0, 8'h00, 2'b11, 8'h02, 2'b00, 4'd6 },  // R6 ACK
        '{7'b0001000, 3'b000, 2'b00, 3'd0, 8'h00, 2'b11, 8'h0B, 2'b00, 4'd11},  // R11 arb drop
        '{7'b0000100, 3'b000, 2'b00, 3'd0, 8'h00, 2'b11, 8'h0C, 2'b00, 4'd11},  // R11 err resync
        '{7'b0000000, 3'b000, 2'b10, CT,   8'h00, 2'b11, 8'h04, 2'b00, 4'd5 },  // R5 ctrl write
        '{7'b0000000, 3'b000, 2'b10, DA,   8'h55, 2'b11, 8'h04, 2'b00, 4'd5 },  // R5 data write
        '{7'b0000000, 3'b000, 2'b10, ST,   8'h08, 2'b11, 8'h04, 2'b00, 4'd8 },  // R8 zero on berr
        '{7'b0000000, 3'b000, 2'b10, AD,   8'hA0, 2'b11, 8'h00, 2'b00, 4'd5 },  // R5 addr write
        '{7'b0000000, 3'b001, 2'b00, 3'd0, 8'h00, 2'b11, 8'h01, 2'b00, 4'd11},  // R11 stop
        '{7'b0000000, 3'b010, 2'b00, 3'd0, 8'h00, 2'b11, 8'h03, 2'b00, 4'd11},  // R11 foreign start
        '{7'b0100000, 3'b000, 2'b10, AD,   8'h00, 2'b00, 8'h43, 2'b00, 4'd7 },  // R7 set beats clear
        '{7'b0000000, 3'b000, 2'b00, 3'd0, 8'h00, 2'b01, 8'h43, 2'b01, 4'd9 },  // R9 enable gate
        '{7'b0000000, 3'b001, 2'b00, 3'd0, 8'h00, 2'b01, 8'h41, 2'b01, 4'd11},  // R11 stop
        '{7'b0101000, 3'b000, 2'b00, 3'd0, 8'h00, 2'b00, 8'h49, 2'b00, 4'd3 },  // R3 wr+arb, idle kept
        '{7'b0000000, 3'b000, 2'b10, ST,   8'hFF, 2'b00, 8'h01, 2'b00, 4'd10},  // R10 R4 0xFF
        '{7'b0000011, 3'b000, 2'b00, 3'd0, 8'h00, 2'b00, 8'h11, 2'b00, 4'd6 },  // R6 NACK
        '{7'b0000000, 3'b000, 2'b10, ST,   8'hFF, 2'b00, 8'h11, 2'b00, 4'd6 },  // R6 read-only
        '{7'b0000000, 3'b100, 2'b00, 3'd0, 8'h00, 2'b00, 8'h12, 2'b00, 4'd11},  // R11 own start
        '{7'b0000000, 3'b100, 2'b00, 3'd0, 8'h00, 2'b00, 8'h12, 2'b00, 4'd11},  // R11 repeated start
        '{7'b0000100, 3'b000, 2'b10, ST,   8'h01, 2'b00, 8'h15, 2'b00, 4'd10},  // R10 force beats err
        '{7'b1000000, 3'b000, 2'b01, DA,   8'h00, 2'b10, 8'h95, 2'b10, 4'd7 },  // R7 read done+data read
        '{7'b0010000, 3'b000, 2'b00, 3'd0, 8'h00, 2'b10, 8'hB5, 2'b10, 4'd12},  // R12 hold
        '{7'b0000000, 3'b000, 2'b01, ST,   8'h00, 2'b10, 8'hB5, 2'b10, 4'd4 },  // R4 status read keeps
        '{7'b0000000, 3'b000, 2'b10, CT,   8'h00, 2'b10, 8'h15, 2'b00, 4'd4 }   // R4 ctrl clears
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       rd_done_i = 0, wr_done_i = 0, hold_i = 0, arb_lost_i = 0, bus_err_i = 0;
    logic       ack_smp_i = 0, ack_nack_i = 0, start_mine_i = 0, start_other_i = 0, stop_i = 0;
    logic       rd_ien_i = 0, wr_ien_i = 0;
    logic [7:0] status_o;
    logic       rd_irq_o, wr_irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    i2c_host_status dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_done_i(rd_done_i), .wr_done_i(wr_done_i), .hold_i(hold_i),
        .arb_lost_i(arb_lost_i), .bus_err_i(bus_err_i), .ack_smp_i(ack_smp_i),
        .ack_nack_i(ack_nack_i), .start_mine_i(start_mine_i),
        .start_other_i(start_other_i), .stop_i(stop_i),
        .rd_ien_i(rd_ien_i), .wr_ien_i(wr_ien_i),
        .status_o(status_o), .rd_irq_o(rd_irq_o), .wr_irq_o(wr_irq_o)
    );

    task automatic check(input int req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: status/irq actual %h/%b expected %h/%b",
                     req, act[9:2], act[1:0], exp[9:2], exp[1:0]);
        end
    endtask

    task automatic strobes_off();
        {rd_done_i, wr_done_i, hold_i, arb_lost_i, bus_err_i, ack_smp_i, ack_nack_i} = '0;
        {start_mine_i, start_other_i, stop_i} = '0;
        {bus_wr, bus_rd} = '0;
        bus_addr = '0;
        bus_wdata = '0;
    endtask

    task automatic apply(input vec_t v);
        {rd_done_i, wr_done_i, hold_i, arb_lost_i, bus_err_i, ack_smp_i, ack_nack_i} = v.ev;
        {start_mine_i, start_other_i, stop_i} = v.bs;
        {bus_wr, bus_rd} = v.op;
        bus_addr = v.addr;
        bus_wdata = v.wd;
        {rd_ien_i, wr_ien_i} = v.ien;
    endtask

    task automatic status_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        strobes_off();
    endtask

    initial begin
        rd_ien_i = 1'b1; wr_ien_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, {status_o, rd_irq_o, wr_irq_o}, {8'h00, 2'b00});   // R1 reset state

        status_write(ST, 8'h02);                                   // R10 non-IDLE value ignored
        check(10, {status_o, rd_irq_o, wr_irq_o}, {8'h00, 2'b00});
        status_write(ST, 8'h03);                                   // R10 BUSY code ignored
        check(10, {status_o, rd_irq_o, wr_irq_o}, {8'h00, 2'b00});
        @(negedge clk);
        start_other_i = 1'b1;                                      // R11 foreign start from UNKNOWN
        @(negedge clk);
        strobes_off();
        check(11, {status_o, rd_irq_o, wr_irq_o}, {8'h03, 2'b00});
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(1, {status_o, rd_irq_o, wr_irq_o}, {8'h00, 2'b00});

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            @(negedge clk);
            strobes_off();
            check(int'(VEC[i].req), {status_o, rd_irq_o, wr_irq_o},
                  {VEC[i].exp_st, VEC[i].exp_irq});
        end

        // R1 reset in the middle of a run with flags set
        @(negedge clk);
        rd_done_i = 1'b1; wr_done_i = 1'b1; bus_err_i = 1'b1;
        @(negedge clk);
        strobes_off();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_ien_i = 1'b1; wr_ien_i = 1'b1;
        check(1, {status_o, rd_irq_o, wr_irq_o}, {8'h00, 2'b00});

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule